// File: doc/BRIEF.md
# Two-Stage Translation Permission Checker

This block decides whether a memory access may proceed, given the permission bits of the guest leaf entry and of the hypervisor leaf entry that together map a guest virtual address to a physical address. It serves two kinds of request. An explicit access is a fetch, load or store issued by the guest. For these it checks the guest stage first and then the hypervisor stage. A walker access is a read or write of a guest page-table entry. For these only the hypervisor stage is checked, as a plain load or store.

Both make-executable-readable controls are inputs that are sampled on every request. A change to either one therefore affects the very next request, with no flush or fence. A translation cache in front of this block keeps only raw entry bits and presents them here each time a cached translation is used. Walker accesses ignore both controls, so a page-table page mapped execute-only always faults. One Sv39 guest walk issues up to three walker accesses, and each is checked as its own request.

The result arrives one cycle after the request, from registers. It carries a fault code and four flags that say which accessed and dirty bits must be set.

Top module: `xlat_perm_check`

## Requirements
- R1: While reset is high, and in the first cycle after it, every output is 0.
- R2: `rsp_valid` equals `req_valid` of the previous cycle. Whenever `rsp_valid` is 0, `rsp_fault` and all four update flags are 0.
- R3: For an explicit access, the guest stage needs the following. A fetch needs X. A store needs W. A load needs R, or needs X with either `vs_mxr` or `hs_mxr` set. Kind encoding: 00 fetch, 01 load, 10 store, 11 checked as a load. Entry bit positions: 0 R, 1 W, 2 X, 3 U, 4 A, 5 D.
- R4: For an explicit access, the guest-stage U bit is checked as follows. In guest user mode (`guest_user`=1), U must be 1. In guest supervisor mode, a U=1 page faults on a fetch and allows a load or store only when `guest_sum`=1.
- R5: For an explicit access, the hypervisor-stage entry needs U=1. A fetch needs X and a store needs W. A load needs R, or needs X with `hs_mxr` set. `vs_mxr` has no effect at this stage.
- R6: `rsp_fault` encoding: 00 pass, 01 page fault (guest stage), 10 guest-page fault (hypervisor stage). When both stages fail, 01 is reported.
- R7: For a walker access (`req_walk`=1), only the hypervisor entry is checked. It needs U=1, plus R for a read (kind other than 10) or W for a write (kind 10). Both MXR inputs and all guest-entry inputs are ignored. The fault code is never 01.
- R8: On a passing access, each stage that was checked flags A for update when its A bit is 0. A store also flags D for update when the D bit is 0. A faulting access, and the guest flags on a walker access, are all 0.
- R9: An MXR change applies to the next request. Two back-to-back requests that differ only in MXR get results that differ accordingly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_walk | input | 1 | 1 = walker access to a guest page-table entry |
| req_kind | input | 2 | Access kind (00 fetch, 01 load, 10 store, 11 load) |
| vs_pte | input | 6 | Guest-stage leaf bits {D,A,U,X,W,R} |
| g_pte | input | 6 | Hypervisor-stage leaf bits {D,A,U,X,W,R} |
| hs_mxr | input | 1 | Hypervisor-level make-executable-readable |
| vs_mxr | input | 1 | Guest-level make-executable-readable |
| guest_user | input | 1 | Guest runs in user mode |
| guest_sum | input | 1 | Guest supervisor may touch user pages |
| rsp_valid | output | 1 | Result present |
| rsp_fault | output | 2 | 00 pass, 01 page fault, 10 guest-page fault |
| upd_vs_a | output | 1 | Guest-stage A must be set |
| upd_vs_d | output | 1 | Guest-stage D must be set |
| upd_g_a | output | 1 | Hypervisor-stage A must be set |
| upd_g_d | output | 1 | Hypervisor-stage D must be set |

## Verification
An exhaustive sweep covers both request types, all four kind codes, every R/W/X/U combination at both stages and all four MXR settings. Each sweep point runs under a different privilege and SUM pair, and with rotating A and D bits. The sweep separates the effect of the guest MXR from that of the hypervisor MXR, and shows which stage a failure is charged to. Directed sequences cover the remaining cases. One toggles MXR between two back-to-back loads of an execute-only page. Another has both stages fail in one request, to show priority. A third presents an execute-only page-table page to the walker with both MXR bits set. Idle cycles inside these sequences show that the outputs return to zero.

// File: rtl/xlat_perm_pkg.sv
package xlat_perm_pkg;
  localparam int PTE_W = 6;
  localparam int B_R = 0;
  localparam int B_W = 1;
  localparam int B_X = 2;
  localparam int B_U = 3;
  localparam int B_A = 4;
  localparam int B_D = 5;

  typedef enum logic [1:0] {
    K_FETCH = 2'b00,
    K_LOAD  = 2'b01,
    K_STORE = 2'b10,
    K_ALT   = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    F_NONE  = 2'b00,
    F_PAGE  = 2'b01,
    F_GUEST = 2'b10
  } fault_e;

  typedef struct packed {
    logic ok;
    logic need_a;
    logic need_d;
  } stage_res_t;
endpackage

// File: rtl/xlat_stage_check.sv
module xlat_stage_check
  import xlat_perm_pkg::*;
#(
  parameter int W = PTE_W
) (
  input  logic [W-1:0] pte,
  input  logic         is_fetch,
  input  logic         is_store,
  input  logic         mxr_eff,
  input  logic         u_ok,
  output stage_res_t   res
);
  logic rd_ok;
  logic kind_ok;

  always_comb begin
    rd_ok = pte[B_R] | (pte[B_X] & mxr_eff);
    if (is_fetch)      kind_ok = pte[B_X];
    else if (is_store) kind_ok = pte[B_W];
    else               kind_ok = rd_ok;
    res.ok     = kind_ok & u_ok;
    res.need_a = ~pte[B_A];
    res.need_d = is_store & ~pte[B_D];
  end
endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
  import xlat_perm_pkg::*;
#(
  parameter int W = PTE_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic         req_walk,
  input  logic [1:0]   req_kind,
  input  logic [W-1:0] vs_pte,
  input  logic [W-1:0] g_pte,
  input  logic         hs_mxr,
  input  logic         vs_mxr,
  input  logic         guest_user,
  input  logic         guest_sum,
  output logic         rsp_valid,
  output logic [1:0]   rsp_fault,
  output logic         upd_vs_a,
  output logic         upd_vs_d,
  output logic         upd_g_a,
  output logic         upd_g_d
);
  logic       is_fetch, is_store;
  logic       vs_fetch, g_fetch;
  logic       vs_u_ok;
  logic       vs_mxr_eff, g_mxr_eff;
  stage_res_t vs_res, g_res;
  logic [1:0] fault_n;
  logic       pass_n;

  always_comb begin
    is_fetch   = (req_kind == K_FETCH);
    is_store   = (req_kind == K_STORE);
    vs_fetch   = is_fetch;
    g_fetch    = is_fetch & ~req_walk;
    vs_mxr_eff = vs_mxr | hs_mxr;
    g_mxr_eff  = hs_mxr & ~req_walk;
    if (guest_user) vs_u_ok = vs_pte[B_U];
    else            vs_u_ok = ~vs_pte[B_U] | (~is_fetch & guest_sum);
  end

  xlat_stage_check #(.W(W)) u_vs (
    .pte(vs_pte), .is_fetch(vs_fetch), .is_store(is_store),
    .mxr_eff(vs_mxr_eff), .u_ok(vs_u_ok), .res(vs_res)
  );

  xlat_stage_check #(.W(W)) u_g (
    .pte(g_pte), .is_fetch(g_fetch), .is_store(is_store),
    .mxr_eff(g_mxr_eff), .u_ok(g_pte[B_U]), .res(g_res)
  );

  always_comb begin
    if (!req_walk && !vs_res.ok) fault_n = F_PAGE;
    else if (!g_res.ok)          fault_n = F_GUEST;
    else                         fault_n = F_NONE;
    pass_n = (fault_n == F_NONE);
  end

  always_ff @(posedge clk) begin
    if (rst || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= F_NONE;
      upd_vs_a  <= 1'b0;
      upd_vs_d  <= 1'b0;
      upd_g_a   <= 1'b0;
      upd_g_d   <= 1'b0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= fault_n;
      upd_vs_a  <= pass_n & ~req_walk & vs_res.need_a;
      upd_vs_d  <= pass_n & ~req_walk & vs_res.need_d;
      upd_g_a   <= pass_n & g_res.need_a;
      upd_g_d   <= pass_n & g_res.need_d;
    end
  end

  assert_valid_follow_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && rsp_fault == 2'b00 && !upd_vs_a && !upd_vs_d && !upd_g_a && !upd_g_d));
  assert_fault_code_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_fault != 2'b11);
  assert_walk_no_vs_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_walk) |=> (rsp_fault != 2'b01 && !upd_vs_a && !upd_vs_d));
  assert_walk_exec_only_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_walk && req_kind != 2'b10 && !g_pte[B_R]) |=> rsp_fault == 2'b10);
  assert_fault_no_update_R8: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault != 2'b00) |-> (!upd_vs_a && !upd_vs_d && !upd_g_a && !upd_g_d));
  assert_dirty_store_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_kind != 2'b10) |=> (!upd_vs_d && !upd_g_d));
endmodule

// File: tb/sim_xlat_perm_check.sv
module sim_xlat_perm_check;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0, req_walk = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [5:0] vs_pte = '0, g_pte = '0;
  logic       hs_mxr = 1'b0, vs_mxr = 1'b0, guest_user = 1'b0, guest_sum = 1'b0;
  logic       rsp_valid, upd_vs_a, upd_vs_d, upd_g_a, upd_g_d;
  logic [1:0] rsp_fault;

  int checks = 0, fails = 0;
  bit done = 0;

  // expected outputs for the request driven in the previous cycle
  logic [6:0] exp_q[$];
  string      tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  xlat_perm_check u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_walk(req_walk),
    .req_kind(req_kind), .vs_pte(vs_pte), .g_pte(g_pte), .hs_mxr(hs_mxr),
    .vs_mxr(vs_mxr), .guest_user(guest_user), .guest_sum(guest_sum),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .upd_vs_a(upd_vs_a),
    .upd_vs_d(upd_vs_d), .upd_g_a(upd_g_a), .upd_g_d(upd_g_d)
  );

  // behavioural model: returns {valid, fault[1:0], vs_a, vs_d, g_a, g_d}
  task automatic model(output logic [6:0] e, output string tag);
    bit st, fe, ld, vsok, gok, uok;
    logic [1:0] f;
    st = (req_kind == 2'd2);
    fe = (req_kind == 2'd0);
    ld = !st && !fe;
    e = '0;
    tag = "R2";
    if (!req_valid) return;
    if (req_walk) begin
      tag = "R7";
      gok = g_pte[3] && (st ? g_pte[1] : g_pte[0]);
      f = gok ? 2'b00 : 2'b10;
      e = {1'b1, f, 2'b00, gok && !g_pte[4], gok && st && !g_pte[5]};
      return;
    end
    vsok = (fe && vs_pte[2]) || (st && vs_pte[1]) ||
           (ld && (vs_pte[0] || (vs_pte[2] && (vs_mxr || hs_mxr))));
    if (guest_user) uok = vs_pte[3];
    else uok = !vs_pte[3] || (guest_sum && !fe);
    gok = g_pte[3] && ((fe && g_pte[2]) || (st && g_pte[1]) ||
          (ld && (g_pte[0] || (g_pte[2] && hs_mxr))));
    if (!uok) begin tag = "R4"; f = 2'b01; end
    else if (!vsok) begin tag = "R3"; f = 2'b01; end
    else if (!gok) begin tag = "R5"; f = 2'b10; end
    else begin tag = "R8"; f = 2'b00; end
    if (f == 2'b00)
      e = {1'b1, f, !vs_pte[4], st && !vs_pte[5], !g_pte[4], st && !g_pte[5]};
    else
      e = {1'b1, f, 4'b0000};
  endtask

  task automatic compare(input logic [6:0] e, input string tag);
    logic [6:0] a;
    a = {rsp_valid, rsp_fault, upd_vs_a, upd_vs_d, upd_g_a, upd_g_d};
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", tag, a, e);
    end
  endtask

  // one cycle: check the previous request's result, then drive the next
  task automatic step(input logic v, input logic wk, input logic [1:0] k,
                      input logic [5:0] vp, input logic [5:0] gp,
                      input logic hm, input logic vm, input logic usr, input logic sm);
    logic [6:0] e;
    string t;
    @(negedge clk);
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    req_valid = v; req_walk = wk; req_kind = k; vs_pte = vp; g_pte = gp;
    hs_mxr = hm; vs_mxr = vm; guest_user = usr; guest_sum = sm;
    model(e, t);
    exp_q.push_back(e);
    tag_q.push_back(t);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1: outputs zero under reset
    compare(7'b0, "R1");
    @(negedge clk);
    rst = 1'b0;
    compare(7'b0, "R1");
    // R2: idle cycle
    step(0, 0, 2'd1, 6'h3f, 6'h3f, 1, 1, 0, 0);
    // R9: hs_mxr toggles between back-to-back loads of an execute-only guest page
    step(1, 0, 2'd1, 6'b011100, 6'b011101, 1, 0, 1, 0);
    step(1, 0, 2'd1, 6'b011100, 6'b011101, 0, 0, 1, 0);
    // R9: hs_mxr toggles on an execute-only hypervisor page
    step(1, 0, 2'd1, 6'b011001, 6'b011100, 1, 0, 1, 0);
    step(1, 0, 2'd1, 6'b011001, 6'b011100, 0, 1, 1, 0);
    // R6: both stages fail, page fault wins
    step(1, 0, 2'd2, 6'b000001, 6'b000001, 0, 0, 1, 0);
    // R7: execute-only page-table page faults even with both MXR set
    step(1, 1, 2'd1, 6'b111111, 6'b011100, 1, 1, 0, 0);
    step(0, 0, 2'd0, 6'h00, 6'h00, 0, 0, 0, 0);
    // R8: store with clear A and D bits on both stages
    step(1, 0, 2'd2, 6'b001011, 6'b001011, 0, 0, 1, 0);
    // exhaustive sweep for R3, R4, R5, R6, R7, R8
    n = 0;
    for (int wk = 0; wk < 2; wk++)
      for (int k = 0; k < 4; k++)
        for (int vp = 0; vp < 16; vp++)
          for (int gp = 0; gp < 16; gp++)
            for (int m = 0; m < 16; m++) begin
              step(1, wk[0], k[1:0], {n[1:0], vp[3:0]}, {n[3:2], gp[3:0]},
                   m[0], m[1], m[2], m[3]);
              n++;
            end
    step(0, 0, 2'd0, 6'h00, 6'h00, 0, 0, 0, 0);
    step(0, 0, 2'd0, 6'h00, 6'h00, 0, 0, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule